// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is a single 16-bit down-counting channel of an interval timer. A one-cycle tick enable, pulsed at the timer input rate (nominally 1.19318 MHz), advances the count. Software reaches the channel through an 8-bit control port and an 8-bit data port. The 16-bit count is loaded as two bytes, low then high, and read back the same way. A control byte either programs the counting mode or freezes a snapshot of the count, so that both bytes of a read come from the same instant.

Three counting behaviours are supported: a one-shot that raises its output at terminal count, a rate generator that pulses its output low once per period, and a square-wave generator. Any control byte the channel cannot honour is ignored and raises a sticky error flag.

Top module: `pit_channel`

## Requirements
- R1: After a synchronous reset the count is 0, `timer_out` is 0, `cfg_err` is 0, `data_rdata` is 0, both byte pointers point at the low byte and no snapshot is pending.
- R2: The control byte has this layout: bits 7:6 select the channel, bits 5:4 set the access kind, bits 3:1 set the mode and bit 0 requests BCD. A byte whose select field is neither `CHAN_SEL` nor 11 is ignored and does not set the error flag.
- R3: The following control bytes are ignored and set `cfg_err`, which stays set until reset: select 11, access 01 or 10, or access 11 with a mode other than 0, 2 or 3 or with bit 0 set.
- R4: A control byte with access 11 and a supported mode stores the mode, stops counting, drives `timer_out` low, returns both byte pointers to the low byte and drops any pending snapshot.
- R5: A data write while the write pointer is on the low byte replaces bits 7:0 of the count, stops counting, drives `timer_out` low and moves the pointer to the high byte.
- R6: A data write on the high byte completes a 16-bit reload value and returns the pointer to the low byte. If that value is nonzero, counting starts, and in modes 2 and 3 `timer_out` goes high. If it is zero, the counter stays halted.
- R7: Each read strobe returns, on `data_rdata` in the following cycle, the low byte and then the high byte in turn. The byte comes from the live count when no snapshot is pending.
- R8: A control byte with access 00 copies the count into a snapshot and returns the read pointer to the low byte, but only when no snapshot is already pending. While a snapshot is pending, reads return its bytes, and reading its high byte releases it.
- R9: Mode 0: each tick decrements the count. The tick that moves the count from 1 to 0 drives `timer_out` high and halts counting.
- R10: Mode 2: the tick that moves the count from 2 to 1 drives `timer_out` low. The tick at count 1 reloads the period and drives `timer_out` high again.
- R11: Mode 3: each tick lowers the count by 2. A tick at a count of 2 or less reloads the period and toggles `timer_out`, so each half period lasts ceil(N/2) ticks.
- R12: In the cycle of a tick, a data write takes effect and the tick is dropped. A snapshot taken in the cycle of a tick holds the count from before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count enable at the timer input rate |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte |
| data_we | input | 1 | Count byte write strobe |
| data_wdata | input | BYTE_W | Count byte to write |
| data_re | input | 1 | Count byte read strobe |
| data_rdata | output | BYTE_W | Byte returned, registered, one cycle after `data_re` |
| timer_out | output | 1 | Counter output |
| cfg_err | output | 1 | Sticky unsupported-command flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a snapshot command and a count tick. The second is a low-byte write and a tick. The bench drives the snapshot control byte and `tick_en` in the same cycle. It then reads both snapshot bytes, which must show the count from before the tick, and then both live bytes, which must show the count one lower. For the second pair it drives a low-byte write and a tick together. Reading back must show the new low byte under an unchanged high byte, with no decrement.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } pit_ctrl_t;

  localparam logic [1:0] ACC_LATCH    = 2'b00;
  localparam logic [1:0] ACC_LOHI     = 2'b11;
  localparam logic [1:0] SEL_READBACK = 2'b11;

  typedef enum logic [2:0] {
    MODE_TERM   = 3'd0,
    MODE_RATE   = 3'd2,
    MODE_SQUARE = 3'd3
  } pit_mode_e;

  function automatic logic mode_supported(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd2) || (m == 3'd3);
  endfunction

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'b00
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic      latch_cmd,
  output logic      prog_stb,
  output pit_mode_e prog_mode,
  output logic      cfg_err
);

  pit_ctrl_t cb;
  logic      mine;
  logic      bad;

  always_comb begin
    cb        = pit_ctrl_t'(ctrl_wdata);
    mine      = ctrl_we && (cb.sel == CHAN_SEL) && (cb.sel != SEL_READBACK);
    latch_cmd = mine && (cb.acc == ACC_LATCH);
    prog_stb  = mine && (cb.acc == ACC_LOHI) && mode_supported(cb.mode) && !cb.bcd;
    prog_mode = pit_mode_e'(cb.mode);
    bad       = ctrl_we && ((cb.sel == SEL_READBACK) ||
                            (mine && (cb.acc != ACC_LATCH) && !prog_stb));
  end

  always_ff @(posedge clk) begin
    if (rst)      cfg_err <= 1'b0;
    else if (bad) cfg_err <= 1'b1;
  end

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R3
  readback_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata[7:6] == 2'b11) |-> (!prog_stb && !latch_cmd));

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                prog_stb,
  input  pit_mode_e           prog_mode,
  input  logic                data_we,
  input  logic [BYTE_W-1:0]   data_wdata,
  output logic [2*BYTE_W-1:0] count_q,
  output logic                out_q
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] reload_v;
  pit_mode_e        mode_q;
  logic             run_q;
  logic             wr_hi_q;

  assign reload_v = {data_wdata, count_q[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      period_q <= '0;
      mode_q   <= MODE_TERM;
      run_q    <= 1'b0;
      wr_hi_q  <= 1'b0;
      out_q    <= 1'b0;
    end else if (prog_stb) begin
      mode_q  <= prog_mode;
      run_q   <= 1'b0;
      wr_hi_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (data_we) begin
      if (!wr_hi_q) begin
        count_q[BYTE_W-1:0] <= data_wdata;
        run_q   <= 1'b0;
        out_q   <= 1'b0;
        wr_hi_q <= 1'b1;
      end else begin
        count_q  <= reload_v;
        period_q <= reload_v;
        run_q    <= (reload_v != '0);
        out_q    <= (reload_v != '0) && (mode_q != MODE_TERM);
        wr_hi_q  <= 1'b0;
      end
    end else if (tick_en && run_q) begin
      case (mode_q)
        MODE_RATE: begin
          if (count_q <= CNT_W'(1)) begin
            count_q <= period_q;
            out_q   <= 1'b1;
          end else begin
            count_q <= count_q - CNT_W'(1);
            out_q   <= (count_q != CNT_W'(2));
          end
        end
        MODE_SQUARE: begin
          if (count_q <= CNT_W'(2)) begin
            count_q <= period_q;
            out_q   <= !out_q;
          end else begin
            count_q <= count_q - CNT_W'(2);
          end
        end
        default: begin
          if (count_q <= CNT_W'(1)) begin
            count_q <= '0;
            out_q   <= 1'b1;
            run_q   <= 1'b0;
          end else begin
            count_q <= count_q - CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R5
  lo_write_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (data_we && !prog_stb && !wr_hi_q) |=> (!out_q && !run_q));

  // R9
  term_count_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_en && !prog_stb && !data_we && mode_q == MODE_TERM &&
     count_q == CNT_W'(1)) |=> (out_q && !run_q));

  // R10
  rate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && mode_q == MODE_RATE && !out_q) |-> (count_q == CNT_W'(1)));

  // R11
  square_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_en && !prog_stb && !data_we && mode_q == MODE_SQUARE &&
     count_q > CNT_W'(2)) |=> (count_q == $past(count_q) - CNT_W'(2) && $stable(out_q)));

  // R12
  write_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && data_we && !prog_stb && !wr_hi_q) |=>
      (count_q[CNT_W-1:BYTE_W] == $past(count_q[CNT_W-1:BYTE_W])));

endmodule

// File: rtl/pit_read_port.sv
module pit_read_port #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                data_re,
  input  logic                latch_cmd,
  input  logic                prog_stb,
  input  logic [2*BYTE_W-1:0] count_i,
  output logic [BYTE_W-1:0]   rdata_q
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] src;
  logic             latched_q;
  logic             rd_hi_q;

  assign src = latched_q ? hold_q : count_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      latched_q <= 1'b0;
      rd_hi_q   <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (data_re)
        rdata_q <= rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
      if (prog_stb) begin
        latched_q <= 1'b0;
        rd_hi_q   <= 1'b0;
      end else begin
        if (data_re) begin
          rd_hi_q <= !rd_hi_q;
          if (rd_hi_q) latched_q <= 1'b0;
        end
        if (latch_cmd && !latched_q) begin
          latched_q <= 1'b1;
          hold_q    <= count_i;
          rd_hi_q   <= 1'b0;
        end
      end
    end
  end

  // R8
  snapshot_held_chk: assert property (@(posedge clk) disable iff (rst)
    (latched_q && !prog_stb && !(data_re && rd_hi_q)) |=> (latched_q && $stable(hold_q)));

  // R8
  snapshot_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_cmd && !latched_q && !prog_stb) |=> (hold_q == $past(count_i) && !rd_hi_q));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter logic [1:0] CHAN_SEL = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] data_wdata,
  input  logic              data_re,
  output logic [BYTE_W-1:0] data_rdata,
  output logic              timer_out,
  output logic              cfg_err
);

  localparam int CNT_W = 2 * BYTE_W;

  logic             latch_cmd;
  logic             prog_stb;
  pit_mode_e        prog_mode;
  logic [CNT_W-1:0] count;

  pit_ctrl_decode #(.CHAN_SEL(CHAN_SEL)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .latch_cmd  (latch_cmd),
    .prog_stb   (prog_stb),
    .prog_mode  (prog_mode),
    .cfg_err    (cfg_err)
  );

  pit_count_core #(.BYTE_W(BYTE_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .prog_stb   (prog_stb),
    .prog_mode  (prog_mode),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .count_q    (count),
    .out_q      (timer_out)
  );

  pit_read_port #(.BYTE_W(BYTE_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .data_re   (data_re),
    .latch_cmd (latch_cmd),
    .prog_stb  (prog_stb),
    .count_i   (count),
    .rdata_q   (data_rdata)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!timer_out && !cfg_err && data_rdata == '0));

endmodule

// File: tb/pit_channel_test.sv
`timescale 1ns/1ps
module pit_channel_test;

  localparam logic [2:0] OP_CTRL  = 3'd0;
  localparam logic [2:0] OP_WR    = 3'd1;
  localparam logic [2:0] OP_RD    = 3'd2;
  localparam logic [2:0] OP_TICK  = 3'd3;
  localparam logic [2:0] OP_OUT   = 3'd4;
  localparam logic [2:0] OP_ERR   = 3'd5;
  localparam logic [2:0] OP_LTICK = 3'd6;
  localparam logic [2:0] OP_WTICK = 3'd7;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int N_VEC = 62;
  localparam vec_t VECS [N_VEC] = '{
    // mode 0 one-shot: R4 R5 R6 R7 R9
    '{OP_CTRL, 8'h30, 8'h00, 8'd4},
    '{OP_WR,   8'h05, 8'h00, 8'd5},
    '{OP_WR,   8'h00, 8'h00, 8'd6},
    '{OP_OUT,  8'h00, 8'h00, 8'd9},
    '{OP_TICK, 8'd2,  8'h00, 8'd9},
    '{OP_RD,   8'h00, 8'h03, 8'd7},
    '{OP_RD,   8'h00, 8'h00, 8'd7},
    '{OP_TICK, 8'd2,  8'h00, 8'd9},
    '{OP_OUT,  8'h00, 8'h00, 8'd9},
    '{OP_TICK, 8'd1,  8'h00, 8'd9},
    '{OP_OUT,  8'h00, 8'h01, 8'd9},
    '{OP_TICK, 8'd3,  8'h00, 8'd9},
    '{OP_RD,   8'h00, 8'h00, 8'd9},
    '{OP_RD,   8'h00, 8'h00, 8'd9},
    '{OP_OUT,  8'h00, 8'h01, 8'd9},
    // low byte write halts: R5, high byte restarts: R6
    '{OP_WR,   8'h34, 8'h00, 8'd5},
    '{OP_OUT,  8'h00, 8'h00, 8'd5},
    '{OP_TICK, 8'd4,  8'h00, 8'd5},
    '{OP_RD,   8'h00, 8'h34, 8'd5},
    '{OP_RD,   8'h00, 8'h00, 8'd5},
    '{OP_WR,   8'h12, 8'h00, 8'd6},
    '{OP_TICK, 8'd1,  8'h00, 8'd6},
    // snapshot: R8
    '{OP_CTRL, 8'h00, 8'h00, 8'd8},
    '{OP_TICK, 8'd3,  8'h00, 8'd8},
    '{OP_RD,   8'h00, 8'h33, 8'd8},
    '{OP_TICK, 8'd1,  8'h00, 8'd8},
    '{OP_CTRL, 8'h00, 8'h00, 8'd8},
    '{OP_RD,   8'h00, 8'h12, 8'd8},
    '{OP_RD,   8'h00, 8'h2F, 8'd7},
    '{OP_RD,   8'h00, 8'h12, 8'd7},
    // snapshot and tick together: R12
    '{OP_LTICK, 8'h00, 8'h00, 8'd12},
    '{OP_RD,   8'h00, 8'h2F, 8'd12},
    '{OP_RD,   8'h00, 8'h12, 8'd12},
    '{OP_RD,   8'h00, 8'h2E, 8'd12},
    '{OP_RD,   8'h00, 8'h12, 8'd12},
    // low write and tick together: R12
    '{OP_WTICK, 8'h40, 8'h00, 8'd12},
    '{OP_RD,   8'h00, 8'h40, 8'd12},
    '{OP_RD,   8'h00, 8'h12, 8'd12},
    '{OP_WR,   8'h00, 8'h00, 8'd6},
    '{OP_TICK, 8'd1,  8'h00, 8'd6},
    '{OP_RD,   8'h00, 8'h3F, 8'd6},
    '{OP_RD,   8'h00, 8'h00, 8'd6},
    // zero reload stays halted: R6
    '{OP_WR,   8'h00, 8'h00, 8'd6},
    '{OP_WR,   8'h00, 8'h00, 8'd6},
    '{OP_TICK, 8'd3,  8'h00, 8'd6},
    '{OP_RD,   8'h00, 8'h00, 8'd6},
    '{OP_RD,   8'h00, 8'h00, 8'd6},
    // mode 2 rate generator: R10
    '{OP_CTRL, 8'h34, 8'h00, 8'd4},
    '{OP_OUT,  8'h00, 8'h00, 8'd4},
    '{OP_WR,   8'h03, 8'h00, 8'd10},
    '{OP_WR,   8'h00, 8'h00, 8'd10},
    '{OP_OUT,  8'h00, 8'h01, 8'd10},
    '{OP_TICK, 8'd1,  8'h00, 8'd10},
    '{OP_OUT,  8'h00, 8'h01, 8'd10},
    '{OP_TICK, 8'd1,  8'h00, 8'd10},
    '{OP_OUT,  8'h00, 8'h00, 8'd10},
    '{OP_TICK, 8'd1,  8'h00, 8'd10},
    '{OP_OUT,  8'h00, 8'h01, 8'd10},
    '{OP_RD,   8'h00, 8'h03, 8'd10},
    '{OP_RD,   8'h00, 8'h00, 8'd10},
    '{OP_TICK, 8'd2,  8'h00, 8'd10},
    '{OP_OUT,  8'h00, 8'h00, 8'd10}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = 8'h00;
  logic       data_re = 1'b0;
  logic [7:0] data_rdata;
  logic       timer_out;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = !clk;

  pit_channel uut (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .data_re    (data_re),
    .data_rdata (data_rdata),
    .timer_out  (timer_out),
    .cfg_err    (cfg_err)
  );

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] arg,
                       input logic [7:0] exp, input int req);
    case (op)
      OP_CTRL: begin
        ctrl_we = 1'b1; ctrl_wdata = arg;
        @(negedge clk);
        ctrl_we = 1'b0;
      end
      OP_WR: begin
        data_we = 1'b1; data_wdata = arg;
        @(negedge clk);
        data_we = 1'b0;
      end
      OP_RD: begin
        data_re = 1'b1;
        @(negedge clk);
        data_re = 1'b0;
        chk(req, data_rdata, exp);
      end
      OP_TICK: begin
        for (int k = 0; k < int'(arg); k++) begin
          tick_en = 1'b1;
          @(negedge clk);
          tick_en = 1'b0;
        end
      end
      OP_OUT: chk(req, {7'd0, timer_out}, exp);
      OP_ERR: chk(req, {7'd0, cfg_err}, exp);
      OP_LTICK: begin
        ctrl_we = 1'b1; ctrl_wdata = 8'h00; tick_en = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0; tick_en = 1'b0;
      end
      default: begin
        data_we = 1'b1; data_wdata = arg; tick_en = 1'b1;
        @(negedge clk);
        data_we = 1'b0; tick_en = 1'b0;
      end
    endcase
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state
    do_op(OP_OUT, 8'h00, 8'h00, 1);
    do_op(OP_ERR, 8'h00, 8'h00, 1);
    chk(1, data_rdata, 8'h00);
    do_op(OP_RD, 8'h00, 8'h00, 1);
    do_op(OP_RD, 8'h00, 8'h00, 1);

    for (int i = 0; i < N_VEC; i++)
      do_op(VECS[i].op, VECS[i].arg, VECS[i].exp, int'(VECS[i].req));

    // R11: square wave, even period
    do_op(OP_CTRL, 8'h36, 8'h00, 11);
    do_op(OP_WR, 8'h04, 8'h00, 11);
    do_op(OP_WR, 8'h00, 8'h00, 11);
    do_op(OP_OUT, 8'h00, 8'h01, 11);
    do_op(OP_TICK, 8'd1, 8'h00, 11);
    do_op(OP_OUT, 8'h00, 8'h01, 11);
    do_op(OP_TICK, 8'd1, 8'h00, 11);
    do_op(OP_OUT, 8'h00, 8'h00, 11);
    do_op(OP_RD, 8'h00, 8'h04, 11);
    do_op(OP_RD, 8'h00, 8'h00, 11);
    do_op(OP_TICK, 8'd2, 8'h00, 11);
    do_op(OP_OUT, 8'h00, 8'h01, 11);
    // R11: odd period 5, half period of 3 ticks
    do_op(OP_CTRL, 8'h36, 8'h00, 11);
    do_op(OP_WR, 8'h05, 8'h00, 11);
    do_op(OP_WR, 8'h00, 8'h00, 11);
    do_op(OP_TICK, 8'd2, 8'h00, 11);
    do_op(OP_OUT, 8'h00, 8'h01, 11);
    do_op(OP_TICK, 8'd1, 8'h00, 11);
    do_op(OP_OUT, 8'h00, 8'h00, 11);
    do_op(OP_RD, 8'h00, 8'h05, 11);
    do_op(OP_RD, 8'h00, 8'h00, 11);

    // R2: another channel's program byte is ignored, no error
    do_op(OP_CTRL, 8'h70, 8'h00, 2);
    do_op(OP_ERR, 8'h00, 8'h00, 2);
    do_op(OP_TICK, 8'd2, 8'h00, 2);
    do_op(OP_OUT, 8'h00, 8'h00, 2);
    do_op(OP_TICK, 8'd1, 8'h00, 2);
    do_op(OP_OUT, 8'h00, 8'h01, 2);

    // R3: unsupported mode 1 ignored, error sticky
    do_op(OP_CTRL, 8'h32, 8'h00, 3);
    do_op(OP_ERR, 8'h00, 8'h01, 3);
    do_op(OP_TICK, 8'd2, 8'h00, 3);
    do_op(OP_OUT, 8'h00, 8'h01, 3);
    do_op(OP_TICK, 8'd1, 8'h00, 3);
    do_op(OP_OUT, 8'h00, 8'h00, 3);
    do_op(OP_RD, 8'h00, 8'h05, 3);
    do_op(OP_RD, 8'h00, 8'h00, 3);
    do_op(OP_ERR, 8'h00, 8'h01, 3);

    // R1: reset clears error; R3: read-back select flagged, no snapshot
    do_reset();
    do_op(OP_ERR, 8'h00, 8'h00, 1);
    do_op(OP_OUT, 8'h00, 8'h00, 1);
    do_op(OP_CTRL, 8'h30, 8'h00, 3);
    do_op(OP_WR, 8'h09, 8'h00, 3);
    do_op(OP_WR, 8'h00, 8'h00, 3);
    do_op(OP_CTRL, 8'hC0, 8'h00, 3);
    do_op(OP_ERR, 8'h00, 8'h01, 3);
    do_op(OP_TICK, 8'd2, 8'h00, 3);
    do_op(OP_RD, 8'h00, 8'h07, 3);
    do_op(OP_RD, 8'h00, 8'h00, 3);

    // R3: access 01 flagged
    do_reset();
    do_op(OP_CTRL, 8'h10, 8'h00, 3);
    do_op(OP_ERR, 8'h00, 8'h01, 3);
    // R3: BCD flagged, mode stays 0 so output does not go high at start
    do_reset();
    do_op(OP_CTRL, 8'h37, 8'h00, 3);
    do_op(OP_ERR, 8'h00, 8'h01, 3);
    do_op(OP_WR, 8'h02, 8'h00, 3);
    do_op(OP_WR, 8'h00, 8'h00, 3);
    do_op(OP_OUT, 8'h00, 8'h00, 3);

    // R4: program mid-count stops counting and drops a pending snapshot
    do_op(OP_CTRL, 8'h00, 8'h00, 4);
    do_op(OP_CTRL, 8'h30, 8'h00, 4);
    do_op(OP_TICK, 8'd1, 8'h00, 4);
    do_op(OP_RD, 8'h00, 8'h02, 4);
    do_op(OP_RD, 8'h00, 8'h00, 4);
    do_op(OP_OUT, 8'h00, 8'h00, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule